// File: doc/BRIEF.md
# Byte-Wide Register Access Master for a Two-Wire Serial Bus

This block is a bit-level master for the two-wire I2C bus that performs exactly one register access per request. The request gives a direction flag, an 8-bit device byte (direction in bit 0), an 8-bit register index and, for writes, one data byte. The master generates the start condition, shifts each byte out MSB first, clocks a ninth slot for every acknowledge, and finishes with a stop condition. It then raises a one-cycle completion pulse with a three-bit acknowledge status and, for reads, the byte it received.

Both bus lines are open-drain. The master never drives a line high: each line has a pull-low enable and is otherwise left to the pull-up. The incoming data line passes through a two-flop synchroniser. Timing comes from a single down-counter. Every half clock phase lasts `HALF_TICKS` clock cycles, and every idle interval lasts twice that.

A read takes two phases. First the device byte and register index go out as a write. Then the bus returns to idle, a fresh start is issued, and the device byte goes out with bit 0 forced to 1. Eight data bits are then clocked in. A missing acknowledge is recorded in the status but never cuts a transfer short. After the received byte the master leaves the data line released and does not acknowledge it.

Top module: `i2c_reg_master`

## Requirements
- R1: Out of reset, and whenever no transfer is running, `busy_o` is low and both pull-low enables (`scl_oe_o`, `sda_oe_o`) are 0.
- R2: An accepted request keeps both lines released for 2*HALF_TICKS cycles. SDA is then pulled low while SCL stays high, so the first start is seen HALF_TICKS*2+1 cycles after the cycle in which the request was driven.
- R3: Every SCL high pulse inside a transfer lasts HALF_TICKS cycles. The one exception is the pulse ending in the repeated start of a read, which lasts 3*HALF_TICKS. SDA changes only while SCL is low, except at start and stop.
- R4: A write sends exactly three bytes, MSB first, in this order: the device byte unchanged, the register index, the data byte. The transfer has one start and one stop.
- R5: A read sends the device byte unchanged and then the register index. It releases the bus, issues a second start, sends the device byte with bit 0 set to 1, and then shifts in 8 bits MSB first. The result appears on `rd_data_o`. A read has two starts and one stop.
- R6: In every ninth (acknowledge) clock the master releases SDA and samples it. `status_o` bit i is 1 when the sampled line was high (not acknowledged). For writes, bits 0, 1 and 2 belong to the device, index and data bytes. For reads, bit 0 belongs to the read-direction device byte and bit 1 to the index. A not-acknowledged byte never stops the remaining bytes from being sent.
- R7: In a read, the master leaves SDA released during the ninth clock after the received byte, so `status_o` bit 2 is 1 for every read.
- R8: A transfer ends with SDA rising while SCL is high. `done_o` is then high for exactly one cycle, in the first cycle with `busy_o` low. `busy_o` is high from the cycle after acceptance until that point.
- R9: A request raised while `busy_o` is high is ignored. It starts no transfer and does not change the bytes of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, accepted only while idle |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_dev_i | input | 8 | Device byte, direction in bit 0 |
| req_reg_i | input | 8 | Register index |
| req_wdata_i | input | 8 | Data byte for writes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Received byte (valid at `done_o` of a read) |
| status_o | output | 3 | Captured acknowledge bits, 1 = not acknowledged |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The bench builds the master with HALF_TICKS = 4, so idle intervals are 8 cycles and a full read fits in a few hundred cycles. With that setting every one of the eight acknowledge patterns can be swept for both writes and reads, together with a spread of received byte values. A bus model on the bench side decodes starts, stops, bytes and pulse widths cycle by cycle. Because the timing is this short, the exact start delay and the exact SCL high widths, including the long repeated-start pulse, can be checked as whole cycle counts.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_GAP,
        ST_STOP_LO,
        ST_STOP_HI
    } i2cm_state_e;

    typedef struct packed {
        i2cm_state_e st;
        logic [1:0]  byte_idx;
        logic [2:0]  bit_idx;
        logic        wr;
        logic [7:0]  dev;
        logic [7:0]  regi;
        logic [7:0]  wdata;
        logic [7:0]  shreg;
        logic [2:0]  nak;
        logic        done;
    } i2cm_regs_t;

endpackage

// File: rtl/i2cm_sync2.sv
module i2cm_sync2 #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cm_halftimer.sv
module i2cm_halftimer #(
    parameter int MAX_TICKS = 2000,
    localparam int CW = $clog2(MAX_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)             cnt_d = val_i - CW'(1);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
        else                    cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == '0);

    // R3: a loaded interval never exceeds the longest programmed span
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_TICKS - 1));
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
    parameter int HALF_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       req_write_i,
    input  logic [7:0] req_dev_i,
    input  logic [7:0] req_reg_i,
    input  logic [7:0] req_wdata_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rd_data_o,
    output logic [2:0] status_o,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    input  logic       sda_i
);
    import i2cm_pkg::*;

    localparam int IDLE_TICKS = 2 * HALF_TICKS;
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] HALF_V = CW'(HALF_TICKS);
    localparam logic [CW-1:0] IDLE_V = CW'(IDLE_TICKS);

    i2cm_regs_t    d, q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    logic          sda_s;
    logic [7:0]    tx_byte;
    logic [1:0]    ack_slot;

    i2cm_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2cm_halftimer #(.MAX_TICKS(IDLE_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
        .expire_o(tmr_exp)
    );

    // byte on the wire for the current slot; the received slot sends all ones
    always_comb begin
        case (q.byte_idx)
            2'd0:    tx_byte = q.dev;
            2'd1:    tx_byte = q.regi;
            2'd2:    tx_byte = q.wr ? q.wdata : (q.dev | 8'h01);
            default: tx_byte = 8'hFF;
        endcase
        if (!q.wr && q.byte_idx == 2'd2) ack_slot = 2'd0;
        else if (q.byte_idx == 2'd3)     ack_slot = 2'd2;
        else                             ack_slot = q.byte_idx;
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = HALF_V;
        case (q.st)
            ST_IDLE: if (req_i) begin
                d.st       = ST_PRE;
                d.wr       = req_write_i;
                d.dev      = req_dev_i;
                d.regi     = req_reg_i;
                d.wdata    = req_wdata_i;
                d.byte_idx = 2'd0;
                d.nak      = 3'b000;
                tmr_load   = 1'b1;
                tmr_val    = IDLE_V;
            end
            ST_PRE: if (tmr_exp) begin
                d.st = ST_START; tmr_load = 1'b1;
            end
            ST_START: if (tmr_exp) begin
                d.st = ST_BIT_LO; d.bit_idx = 3'd7; tmr_load = 1'b1;
            end
            ST_BIT_LO: if (tmr_exp) begin
                d.st = ST_BIT_HI; tmr_load = 1'b1;
            end
            ST_BIT_HI: if (tmr_exp) begin
                d.shreg  = {q.shreg[6:0], sda_s};
                tmr_load = 1'b1;
                if (q.bit_idx == 3'd0) d.st = ST_ACK_LO;
                else begin
                    d.st      = ST_BIT_LO;
                    d.bit_idx = q.bit_idx - 3'd1;
                end
            end
            ST_ACK_LO: if (tmr_exp) begin
                d.st = ST_ACK_HI; tmr_load = 1'b1;
            end
            ST_ACK_HI: if (tmr_exp) begin
                d.nak[ack_slot] = sda_s;
                tmr_load        = 1'b1;
                if ((q.wr && q.byte_idx == 2'd2) || q.byte_idx == 2'd3) begin
                    d.st = ST_STOP_LO;
                end else if (!q.wr && q.byte_idx == 2'd1) begin
                    d.st       = ST_GAP;
                    d.byte_idx = 2'd2;
                    tmr_val    = IDLE_V;
                end else begin
                    d.st       = ST_BIT_LO;
                    d.byte_idx = q.byte_idx + 2'd1;
                    d.bit_idx  = 3'd7;
                end
            end
            ST_GAP: if (tmr_exp) begin
                d.st = ST_PRE; tmr_load = 1'b1; tmr_val = IDLE_V;
            end
            ST_STOP_LO: if (tmr_exp) begin
                d.st = ST_STOP_HI; tmr_load = 1'b1;
            end
            ST_STOP_HI: if (tmr_exp) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        scl_oe_o = q.st inside {ST_BIT_LO, ST_ACK_LO, ST_GAP, ST_STOP_LO};
        case (q.st)
            ST_START, ST_STOP_LO, ST_STOP_HI: sda_oe_o = 1'b1;
            ST_BIT_LO, ST_BIT_HI:             sda_oe_o = ~tx_byte[q.bit_idx];
            default:                          sda_oe_o = 1'b0;
        endcase
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
    assign rd_data_o = q.shreg;
    assign status_o  = q.nak;

    // R1: an idle master leaves both lines to the pull-ups
    a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));
    // R3: data line holds still for the whole SCL high phase
    a_r3_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_BIT_HI || q.st == ST_ACK_HI) && $past(q.st) == q.st)
        |-> $stable(sda_oe_o));
    // R6: acknowledge clock never pulled low by the master
    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK_LO || q.st == ST_ACK_HI) |-> !sda_oe_o);
    // R8: completion is a single pulse, coincident with the end of busy
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R9: a request during a transfer leaves the latched request untouched
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> ($stable(q.dev) && $stable(q.regi) &&
                               $stable(q.wdata) && $stable(q.wr)));

    initial begin
        a_r3_half_min: assert (HALF_TICKS >= 3);
    end
endmodule

// File: tb/sim_i2c_reg_master.sv
module sim_i2c_reg_master;
    localparam int HALF = 4;
    localparam int IDLE = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_wr = 1'b0;
    logic [7:0] req_dev = '0, req_reg = '0, req_wd = '0;
    logic       busy, done, scl_oe, sda_oe, sda_in;
    logic [7:0] rd_data;
    logic [2:0] status;
    logic       s_oe = 1'b0;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;

    assign sda_in = ~(sda_oe | s_oe);

    always #2.5 clk = ~clk;

    i2c_reg_master #(.HALF_TICKS(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_write_i(req_wr),
        .req_dev_i(req_dev), .req_reg_i(req_reg), .req_wdata_i(req_wd),
        .busy_o(busy), .done_o(done), .rd_data_o(rd_data), .status_o(status),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_in)
    );

    // bus model state
    logic       m_rd;
    logic [2:0] m_ack;
    logic [7:0] m_rv;
    logic [7:0] caps [4];
    logic [7:0] shreg;
    int bitpos, byte_no, starts, stops, long_cnt, bad_cnt, drive_err;
    int done_cnt, first_start_cyc, hi_start;
    bit first_fall;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // target device model and monitor, sampled mid-cycle
    initial forever begin
        logic cs, cd;
        @(negedge clk);
        cs = ~scl_oe;
        cd = ~(sda_oe | s_oe);
        if (done) done_cnt++;
        if (prev_scl && cs && prev_sda && !cd) begin
            starts++;
            bitpos = 0;
            if (starts == 1) first_start_cyc = cyc;
        end
        if (prev_scl && cs && !prev_sda && cd) stops++;
        if (!prev_scl && cs) begin
            hi_start = cyc;
            if (bitpos == 8 && sda_oe) drive_err++;
            if (bitpos < 8) shreg = {shreg[6:0], cd};
            bitpos++;
            if (bitpos == 9) begin
                if (byte_no < 4) caps[byte_no] = shreg;
                byte_no++;
                bitpos = 0;
            end
        end
        if (prev_scl && !cs) begin
            if (first_fall) first_fall = 1'b0;
            else if (cyc - hi_start == 3 * HALF) long_cnt++;
            else if (cyc - hi_start != HALF) bad_cnt++;
            if (bitpos == 8 && !(m_rd && byte_no == 3))
                s_oe = (byte_no < 3) ? m_ack[byte_no] : 1'b0;
            else if (m_rd && byte_no == 3 && bitpos < 8)
                s_oe = ~m_rv[7 - bitpos];
            else
                s_oe = 1'b0;
        end
        prev_scl = cs;
        prev_sda = cd;
    end

    task automatic run(input bit wr, input logic [7:0] dev, input logic [7:0] idx,
                       input logic [7:0] wd, input logic [2:0] am,
                       input logic [7:0] rv, input bit poke);
        int req_cyc, to;
        logic [2:0] exp_st;
        m_rd = !wr; m_ack = am; m_rv = rv;
        for (int i = 0; i < 4; i++) caps[i] = 8'h00;
        bitpos = 0; byte_no = 0; starts = 0; stops = 0; long_cnt = 0;
        bad_cnt = 0; drive_err = 0; done_cnt = 0; first_fall = 1'b1;
        first_start_cyc = 0;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_dev = dev; req_reg = idx; req_wd = wd;
        req_cyc = cyc;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            req = 1'b1; req_wr = ~wr; req_dev = ~dev; req_reg = ~idx; req_wd = ~wd;
            @(negedge clk);
            req = 1'b0;
        end
        to = 0;
        while (done_cnt == 0 && to < 5000) begin
            @(negedge clk);
            to++;
        end
        repeat (3 * IDLE) @(negedge clk);
        chk(done_cnt == 1, "R8 single done", done_cnt, 1);
        chk(busy == 1'b0, "R9 no follow-on transfer", busy, 0);
        chk(stops == 1, "R8 one stop", stops, 1);
        chk(first_start_cyc - req_cyc == IDLE + 1, "R2 start delay",
            first_start_cyc - req_cyc, IDLE + 1);
        chk(bad_cnt == 0, "R3 SCL high width", bad_cnt, 0);
        chk(long_cnt == (wr ? 0 : 1), "R3 repeated-start pulse", long_cnt, wr ? 0 : 1);
        chk(drive_err == 0, "R6 R7 ninth clock released", drive_err, 0);
        chk(caps[0] == dev, "R4 R5 device byte", caps[0], dev);
        chk(caps[1] == idx, "R4 R5 index byte", caps[1], idx);
        if (wr) begin
            chk(starts == 1, "R4 one start", starts, 1);
            chk(byte_no == 3, "R4 byte count", byte_no, 3);
            chk(caps[2] == wd, "R4 data byte", caps[2], wd);
            exp_st = ~am;
        end else begin
            chk(starts == 2, "R5 two starts", starts, 2);
            chk(byte_no == 4, "R5 byte count", byte_no, 4);
            chk(caps[2] == (dev | 8'h01), "R5 read address", caps[2], dev | 8'h01);
            chk(rd_data == rv, "R5 read data", rd_data, rv);
            exp_st = {1'b1, ~am[1], ~am[2]};
            chk(status[2] == 1'b1, "R7 no master ack", status[2], 1);
        end
        chk(status == exp_st, "R6 ack status", status, exp_st);
        chk(!scl_oe && !sda_oe, "R1 lines released after", {scl_oe, sda_oe}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {busy, done}, 0);
        chk(!scl_oe && !sda_oe, "R1 reset lines", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy, "R1 idle after reset", {scl_oe, sda_oe, busy}, 0);
        for (int a = 0; a < 8; a++) begin
            run(1'b1, 8'h20 + 8'(2 * a), 8'(a * 29), 8'(8'hC3 ^ (a * 17)), 3'(a), 8'h00, a == 3);
            run(1'b0, 8'h90 + 8'(2 * a), 8'(255 - a * 7), 8'h00, 3'(a), 8'(a * 37 + 1), a == 5);
        end
        for (int k = 0; k < 16; k++)
            run(1'b0, 8'h4C, 8'(k), 8'h00, 3'b111, 8'(k * 17) ^ 8'h5A, 1'b0);
        run(1'b0, 8'h55, 8'h80, 8'h00, 3'b111, 8'h80, 1'b0);
        run(1'b0, 8'hA2, 8'h01, 8'h00, 3'b111, 8'h01, 1'b0);
        run(1'b1, 8'hFF, 8'h00, 8'hFF, 3'b111, 8'h00, 1'b0);
        run(1'b1, 8'h00, 8'hFF, 8'h00, 3'b000, 8'h00, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule